// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block holds the digital side of a successive-approximation analog-to-digital converter. A start pulse clears the working register and begins a binary search. The search runs from the most significant bit down to the least. For each bit it raises that bit and drives the resulting trial code to an external DAC. One clock later it reads the external comparator and decides whether to keep the bit or drop it. Bits already decided stay on the DAC lines while the lower bits are tried.

A conversion always lasts exactly `WIDTH` decision cycles, whatever the analog input. When the last bit is settled, the final code is copied into a result register and a one-cycle done pulse is raised. A parameter sets the comparator sense, so the block can work with comparators whose output is high when the input is above the DAC level or high when it is below.

Top module: `sar_ctrl`

## Requirements
- R1: While reset is asserted, and right after it, the DAC code, the result and the done flag are all zero.
- R2: A start pulse sampled while the block is idle clears the working register. On the following cycle the DAC code has only bit `WIDTH-1` set.
- R3: Bits are tried from bit `WIDTH-1` down to bit 0, one per cycle. During a trial, the bit under test is 1 and every bit below it is 0.
- R4: With `CMP_INV=0`, a comparator input of 1 means the analog input is at or above the trial level. At the next edge the trial bit is kept when the comparator is 1 and cleared when it is 0.
- R5: Bits already decided stay unchanged on the DAC code while lower bits are tried.
- R6: `done_o` is high for exactly one cycle. It rises `WIDTH` cycles after the edge that accepted the start, and it is never high on two cycles in a row.
- R7: With an ideal DAC and comparator, the result is the largest code whose DAC level does not exceed the input. The result saturates at all ones.
- R8: A start pulse sampled while a conversion is running has no effect on the trial sequence, the completion time or the result.
- R9: `result_o` changes only at the edge that ends a conversion and holds its value between conversions.
- R10: A start pulse given in the cycle where `done_o` is high is accepted, so conversions can run back to back.
- R11: With `CMP_INV=1`, the comparator sense is inverted: a comparator input of 0 keeps the trial bit. A 4-bit instance with unit-volt weights and a 5.1 V input then yields 0101.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a conversion, honoured only when idle |
| cmp_i | input | 1 | Comparator decision for the current trial code |
| dac_code_o | output | WIDTH | Trial code driven to the external DAC |
| result_o | output | WIDTH | Last completed conversion result |
| done_o | output | 1 | One-cycle pulse marking the end of a conversion |

## Verification
The bench builds two instances. The first is a 6-bit instance with the default comparator sense. Its full code range of 64 levels is small enough that directed inputs reach zero, exact level boundaries, full scale and inputs above full scale. Random inputs then fill in the middle of the range. The second is a 4-bit instance with the inverted comparator sense. It brings in the generate variant for comparator polarity and reproduces the 5.1 V example against unit-volt bit weights.

// File: rtl/sar_pkg.sv
package sar_pkg;
   typedef enum logic [0:0] {
      SAR_IDLE = 1'b0,
      SAR_CONV = 1'b1
   } sar_phase_e;
endpackage

// File: rtl/sar_step.sv
module sar_step #(
   parameter int WIDTH = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   output logic             load_o,
   output logic             busy_o,
   output logic             last_o,
   output logic [WIDTH-1:0] mask_o
);
   import sar_pkg::*;

   localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

   sar_phase_e       phase_q;
   logic [WIDTH-1:0] mask_q;

   assign busy_o = (phase_q == SAR_CONV);
   assign load_o = start_i && !busy_o;
   assign last_o = busy_o && mask_q[0];
   assign mask_o = mask_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q <= SAR_IDLE;
         mask_q  <= '0;
      end else if (load_o) begin
         phase_q <= SAR_CONV;
         mask_q  <= TOP_BIT;
      end else if (busy_o) begin
         mask_q <= mask_q >> 1;
         if (mask_q[0]) phase_q <= SAR_IDLE;
      end
   end
endmodule

// File: rtl/sar_pol.sv
module sar_pol #(
   parameter bit CMP_INV = 1'b0
) (
   input  logic cmp_i,
   output logic keep_o
);
   generate
      if (CMP_INV) begin : g_inv
         assign keep_o = ~cmp_i;
      end else begin : g_dir
         assign keep_o = cmp_i;
      end
   endgenerate
endmodule

// File: rtl/sar_bits.sv
module sar_bits #(
   parameter int WIDTH = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic             busy_i,
   input  logic             keep_i,
   input  logic [WIDTH-1:0] mask_i,
   output logic [WIDTH-1:0] code_o,
   output logic [WIDTH-1:0] decided_o
);
   localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

   logic [WIDTH-1:0] code_q;

   // trial bit resolved against the comparator, lower bits untouched
   assign decided_o = keep_i ? code_q : (code_q & ~mask_i);
   assign code_o    = code_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         code_q <= '0;
      end else if (load_i) begin
         code_q <= TOP_BIT;
      end else if (busy_i) begin
         code_q <= decided_o | (mask_i >> 1);
      end
   end
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
   parameter int WIDTH   = 8,
   parameter bit CMP_INV = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic             cmp_i,
   output logic [WIDTH-1:0] dac_code_o,
   output logic [WIDTH-1:0] result_o,
   output logic             done_o
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("sar_ctrl: WIDTH must be at least 2");
      end
   endgenerate

   logic             load_w;
   logic             busy_w;
   logic             last_w;
   logic             keep_w;
   logic [WIDTH-1:0] mask_w;
   logic [WIDTH-1:0] decided_w;
   logic [WIDTH-1:0] result_q;
   logic             done_q;

   sar_step #(.WIDTH(WIDTH)) u_step (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .start_i(start_i),
      .load_o (load_w),
      .busy_o (busy_w),
      .last_o (last_w),
      .mask_o (mask_w)
   );

   sar_pol #(.CMP_INV(CMP_INV)) u_pol (
      .cmp_i (cmp_i),
      .keep_o(keep_w)
   );

   sar_bits #(.WIDTH(WIDTH)) u_bits (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (load_w),
      .busy_i   (busy_w),
      .keep_i   (keep_w),
      .mask_i   (mask_w),
      .code_o   (dac_code_o),
      .decided_o(decided_w)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         result_q <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= last_w;
         if (last_w) result_q <= decided_w;
      end
   end

   assign result_o = result_q;
   assign done_o   = done_q;
endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             done_o,
   input logic             busy,
   input logic [WIDTH-1:0] trial_mask,
   input logic [WIDTH-1:0] dac_code_o,
   input logic [WIDTH-1:0] result_o
);
   localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};
   localparam logic [WIDTH-1:0] ONE     = {{(WIDTH-1){1'b0}}, 1'b1};

   assert_start_msb_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy) |=> (dac_code_o == TOP_BIT));

   assert_trial_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ($countones(trial_mask) == 1));

   assert_below_trial_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (((dac_code_o & (trial_mask - ONE)) == '0) && ((dac_code_o & trial_mask) != '0)));

   assert_upper_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |->
      (((dac_code_o ^ $past(dac_code_o)) & ~(($past(trial_mask) << 1) - ONE)) == '0));

   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start_i && !trial_mask[0]) |=> (busy && (trial_mask == ($past(trial_mask) >> 1))));

   assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(result_o));
endmodule

bind sar_ctrl sar_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
   .clk       (clk_i),
   .rst_n     (rst_ni),
   .start_i   (start_i),
   .done_o    (done_o),
   .busy      (busy_w),
   .trial_mask(mask_w),
   .dac_code_o(dac_code_o),
   .result_o  (result_o)
);

// File: tb/sim_sar_ctrl.sv
module sim_sar_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int W0 = 6;
   localparam int W1 = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start0 = 1'b0;
   logic start1 = 1'b0;
   int   vin0 = 0;   // analog input in tenths of an LSB
   int   vin1 = 0;
   int   checks = 0;
   int   errors = 0;

   logic [W0-1:0] dac0, res0;
   logic [W1-1:0] dac1, res1;
   logic done0, done1, cmp0, cmp1;

   // ideal DAC and comparators
   assign cmp0 = (vin0 >= int'(dac0) * 10);
   assign cmp1 = !(vin1 >= int'(dac1) * 10);

   always #(CLK_PERIOD/2) clk = ~clk;

   sar_ctrl #(.WIDTH(W0), .CMP_INV(1'b0)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start0), .cmp_i(cmp0),
      .dac_code_o(dac0), .result_o(res0), .done_o(done0));

   sar_ctrl #(.WIDTH(W1), .CMP_INV(1'b1)) u1 (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start1), .cmp_i(cmp1),
      .dac_code_o(dac1), .result_o(res1), .done_o(done1));

   function automatic int ideal_code(int v, int w);
      int top = (1 << w) - 1;
      return (v / 10 > top) ? top : v / 10;
   endfunction

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // one conversion on u0; poke raises start mid-way, b2b leaves at the done cycle
   task automatic run0(int v, bit poke, bit b2b);
      int dec = 0;
      vin0 = v;
      start0 = 1'b1;
      @(negedge clk);
      start0 = 1'b0;
      for (int i = W0 - 1; i >= 0; i--) begin
         if (i == W0 - 1) chk("R2 first trial code", int'(dac0), 1 << i);
         else chk("R3 R4 R5 trial code", int'(dac0), dec | (1 << i));
         chk("R6 done low while converting", int'(done0), 0);
         if (v >= (dec | (1 << i)) * 10) dec = dec | (1 << i);
         if (poke && i == W0 / 2) start0 = 1'b1;
         @(negedge clk);
         start0 = 1'b0;
      end
      chk("R6 done after WIDTH cycles", int'(done0), 1);
      chk("R7 result vs ideal", int'(res0), ideal_code(v, W0));
      if (!b2b) begin
         @(negedge clk);
         chk("R6 done single cycle", int'(done0), 0);
      end
   endtask

   task automatic run1(int v, int exp);
      vin1 = v;
      start1 = 1'b1;
      @(negedge clk);
      start1 = 1'b0;
      repeat (W1) @(negedge clk);
      chk("R11 inverted sense done", int'(done1), 1);
      chk("R11 inverted sense result", int'(res1), exp);
      @(negedge clk);
   endtask

   initial begin
      int seed;
      int held;
      repeat (3) @(negedge clk);
      chk("R1 reset dac", int'(dac0), 0);
      chk("R1 reset result", int'(res0), 0);
      chk("R1 reset done", int'(done0), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset dac", int'(dac0), 0);

      run0(0, 1'b0, 1'b0);
      run0(5, 1'b0, 1'b0);
      run0(9, 1'b0, 1'b0);
      run0(10, 1'b0, 1'b0);
      run0(315, 1'b0, 1'b0);
      run0(320, 1'b0, 1'b0);
      run0(630, 1'b0, 1'b0);
      run0(639, 1'b0, 1'b0);
      run0(1000, 1'b0, 1'b0);

      // R10: back to back, start given while done is high
      run0(200, 1'b0, 1'b1);
      run0(455, 1'b0, 1'b0);

      // R8: start raised in the middle of a conversion
      run0(377, 1'b1, 1'b0);

      // R9: result holds while the input moves and no start arrives
      held = int'(res0);
      vin0 = 5;
      repeat (4) @(negedge clk);
      vin0 = 600;
      repeat (4) @(negedge clk);
      chk("R9 result held between conversions", int'(res0), held);
      chk("R9 done stays low when idle", int'(done0), 0);

      seed = $urandom(32'd4242);
      for (int n = 0; n < 40; n++) begin
         run0(int'($urandom_range(0, 700)), 1'b0, 1'b0);
      end

      run1(51, 5);
      run1(160, 15);
      run1(0, 0);
      run1(79, 7);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      checks++;
      errors++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule